// File: doc/BRIEF.md
# Ping-Pong Memory Iteration Controller

This block sequences a cellular automaton engine that keeps two lattice images in two memory banks. One bank is read as the current state while the other receives the next state. The controller reads words from the source bank at consecutive addresses starting at zero, one per cycle. It issues the matching destination writes a fixed number of cycles later, to account for the neighbourhood window and the update logic between the two banks. When the last write of a pass has been issued, the two banks exchange roles and the next pass begins.

A host programs the engine through a small register file: a control word, a read-only status word, a pass limit, the number of words per pass, and four rule parameter words. The rule words are driven straight out to the update logic, so the rules can change between runs without any other action. The run stops in one of two ways. In count mode it stops after the programmed number of passes. In settle mode it stops after the first pass in which the update logic reported no changed word, with the pass limit still acting as an upper bound. When the run stops, a done flag is raised and the status word records the stop reason and the number of passes completed.

Top module: `pingpong_iter_ctrl`

## Requirements
- R1: After reset, rd_en, wr_en, done and src_bank are 0, and every host register reads back as 0.
- R2: The host register map is: address 0 control, address 2 pass limit, address 3 words per pass, addresses 4 to 7 rule words 0 to 3. While the controller is idle or done, a write to any of these takes effect at the next clock and reads back. Rule word k drives rules[32k+31:32k].
- R3: A host write made while a run is in progress changes no register and no rules output. This includes a start request.
- R4: A control write with bit 0 set starts a run, and bit 1 selects the mode (0 = count, 1 = settle). In the cycle after such a write, rd_en is 1 with rd_addr 0. Each pass then reads addresses 0 to N-1 on consecutive cycles, where N is the words-per-pass value.
- R5: wr_en and wr_addr equal rd_en and rd_addr from LAT cycles earlier.
- R6: After the last write of a pass, there is one cycle with neither a read nor a write. src_bank then toggles, and the next pass or the done state begins in the following cycle.
- R7: In count mode, the run stops after exactly L passes, where L is the pass limit, whatever word_changed does. While done is 1, no read or write is issued.
- R8: In settle mode, the run stops after the first pass in which word_changed was never 1 during a write cycle, with stop reason 1. If L passes complete first, the run stops with stop reason 0.
- R9: word_changed has no effect in any cycle in which wr_en is 0.
- R10: A start with N = 0 or L = 0 raises done in the next cycle. No read is issued, src_bank keeps its value, and the completed-pass count is 0.
- R11: The status word at address 1 has done in bit 0, busy in bit 1, src_bank in bit 2, the stop reason in bit 3 and the completed-pass count in bits 31:8.
- R12: A new start from the done state clears done, the completed-pass count and the stop reason, and runs with the current register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational) |
| word_changed | input | 1 | Update logic reports that the word being written differs from its source |
| rd_en | output | 1 | Source bank read enable |
| rd_addr | output | ADDR_W | Source bank read address |
| wr_en | output | 1 | Destination bank write enable |
| wr_addr | output | ADDR_W | Destination bank write address |
| src_bank | output | 1 | Bank currently acting as source (the other bank is the destination) |
| rules | output | 128 | Four rule parameter words for the update logic |
| done | output | 1 | The run has stopped |

## Verification
The bound checker checks the following on every cycle: the fixed write delay relative to the reads, the address step within a pass, the zero start address of each pass, the quiet cycle before every bank toggle, the absence of memory traffic while done, and the rule outputs being frozen during a run. Some behaviour only shows over a whole run, so only the bench scenarios can show it: the exact number of passes, the settle-mode stop after a quiet pass, word_changed being ignored outside write cycles, the zero-size starts, the rejected writes during a run, and the status fields. The bench sweeps word counts 1 to 5 against pass limits 1 to 3 and checks every cycle of every pass against positions computed from N and LAT.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
    localparam int HOST_W    = 32;
    localparam int NUM_RULES = 4;
    localparam int RULE_W    = HOST_W;

    localparam logic [2:0] A_CTRL   = 3'd0;
    localparam logic [2:0] A_STATUS = 3'd1;
    localparam logic [2:0] A_LIMIT  = 3'd2;
    localparam logic [2:0] A_WORDS  = 3'd3;
    localparam logic [2:0] A_RULE0  = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_DRAIN,
        ST_SWAP,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/ppc_delay_line.sv
module ppc_delay_line #(
    parameter int W     = 9,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    logic [DEPTH-1:0][W-1:0] pipe_d, pipe_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign pipe_d[g] = in_i;
        end else begin : g_body
            assign pipe_d[g] = pipe_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/ppc_regs.sv
module ppc_regs
    import ppc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ITER_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_we,
    input  logic [2:0]                  host_addr,
    input  logic [HOST_W-1:0]           host_wdata,
    output logic [HOST_W-1:0]           host_rdata,
    input  logic                        cfg_open_i,
    input  logic                        st_done_i,
    input  logic                        st_busy_i,
    input  logic                        st_bank_i,
    input  logic                        st_reason_i,
    input  logic [ITER_W-1:0]           st_iter_i,
    output logic                        start_o,
    output logic                        mode_o,
    output logic [ITER_W-1:0]           limit_o,
    output logic [ADDR_W:0]             words_o,
    output logic [NUM_RULES*RULE_W-1:0] rules_o
);
    typedef struct packed {
        logic                             mode;
        logic [ITER_W-1:0]                limit;
        logic [ADDR_W:0]                  words;
        logic [NUM_RULES-1:0][RULE_W-1:0] rule;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_ok;

    assign wr_ok = host_we && cfg_open_i;

    always_comb begin
        r_d = r_q;
        if (wr_ok) begin
            unique case (host_addr)
                A_CTRL:  r_d.mode  = host_wdata[1];
                A_LIMIT: r_d.limit = host_wdata[ITER_W-1:0];
                A_WORDS: r_d.words = host_wdata[ADDR_W:0];
                A_STATUS: ;
                default: r_d.rule[host_addr[1:0]] = host_wdata;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign start_o = wr_ok && (host_addr == A_CTRL) && host_wdata[0];
    assign mode_o  = r_q.mode;
    assign limit_o = r_q.limit;
    assign words_o = r_q.words;
    assign rules_o = r_q.rule;

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            A_CTRL:   host_rdata[1] = r_q.mode;
            A_STATUS: begin
                host_rdata[0]           = st_done_i;
                host_rdata[1]           = st_busy_i;
                host_rdata[2]           = st_bank_i;
                host_rdata[3]           = st_reason_i;
                host_rdata[8 +: ITER_W] = st_iter_i;
            end
            A_LIMIT:  host_rdata[ITER_W-1:0] = r_q.limit;
            A_WORDS:  host_rdata[ADDR_W:0]   = r_q.words;
            default:  host_rdata = r_q.rule[host_addr[1:0]];
        endcase
    end
endmodule

// File: rtl/ppc_seq.sv
module ppc_seq
    import ppc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ITER_W = 16,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [ITER_W-1:0] limit_i,
    input  logic [ADDR_W:0]   words_i,
    input  logic              wr_en_i,
    input  logic              word_changed_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              bank_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              cfg_open_o,
    output logic              reason_o,
    output logic [ITER_W-1:0] iter_o
);
    localparam int DW = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [DW-1:0] DLAST = DW'(LAT - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W:0]   rcnt;
        logic [DW-1:0]     dcnt;
        logic [ITER_W-1:0] iter;
        logic              changed;
        logic              bank;
        logic              reason;
    } seq_t;

    seq_t              s_d, s_q;
    logic [ITER_W-1:0] iter_nx;

    assign iter_nx = s_q.iter + 1'b1;

    always_comb begin
        s_d = s_q;
        if (wr_en_i && word_changed_i) s_d.changed = 1'b1;
        unique case (s_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    s_d.iter    = '0;
                    s_d.reason  = 1'b0;
                    s_d.changed = 1'b0;
                    s_d.rcnt    = '0;
                    s_d.st      = (words_i == '0 || limit_i == '0) ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                if (s_q.rcnt == words_i - 1'b1) begin
                    s_d.st   = ST_DRAIN;
                    s_d.dcnt = '0;
                end else begin
                    s_d.rcnt = s_q.rcnt + 1'b1;
                end
            end
            ST_DRAIN: begin
                if (s_q.dcnt == DLAST) s_d.st   = ST_SWAP;
                else                   s_d.dcnt = s_q.dcnt + 1'b1;
            end
            ST_SWAP: begin
                s_d.bank = ~s_q.bank;
                s_d.iter = iter_nx;
                if (iter_nx == limit_i) begin
                    s_d.st     = ST_DONE;
                    s_d.reason = 1'b0;
                end else if (mode_i && !s_q.changed) begin
                    s_d.st     = ST_DONE;
                    s_d.reason = 1'b1;
                end else begin
                    s_d.st      = ST_RUN;
                    s_d.rcnt    = '0;
                    s_d.changed = 1'b0;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_en_o    = (s_q.st == ST_RUN);
    assign rd_addr_o  = s_q.rcnt[ADDR_W-1:0];
    assign bank_o     = s_q.bank;
    assign done_o     = (s_q.st == ST_DONE);
    assign busy_o     = (s_q.st == ST_RUN) || (s_q.st == ST_DRAIN) || (s_q.st == ST_SWAP);
    assign cfg_open_o = (s_q.st == ST_IDLE) || (s_q.st == ST_DONE);
    assign reason_o   = s_q.reason;
    assign iter_o     = s_q.iter;
endmodule

// File: rtl/pingpong_iter_ctrl.sv
module pingpong_iter_ctrl
    import ppc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int ITER_W = 16,
    parameter int LAT    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        host_we,
    input  logic [2:0]                  host_addr,
    input  logic [HOST_W-1:0]           host_wdata,
    output logic [HOST_W-1:0]           host_rdata,
    input  logic                        word_changed,
    output logic                        rd_en,
    output logic [ADDR_W-1:0]           rd_addr,
    output logic                        wr_en,
    output logic [ADDR_W-1:0]           wr_addr,
    output logic                        src_bank,
    output logic [NUM_RULES*RULE_W-1:0] rules,
    output logic                        done
);
    localparam int PW = ADDR_W + 1;

    logic              start, mode, cfg_open, busy, reason;
    logic [ITER_W-1:0] limit, iter;
    logic [ADDR_W:0]   words;
    logic [PW-1:0]     wr_tag;

    ppc_regs #(.ADDR_W(ADDR_W), .ITER_W(ITER_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .cfg_open_i  (cfg_open),
        .st_done_i   (done),
        .st_busy_i   (busy),
        .st_bank_i   (src_bank),
        .st_reason_i (reason),
        .st_iter_i   (iter),
        .start_o     (start),
        .mode_o      (mode),
        .limit_o     (limit),
        .words_o     (words),
        .rules_o     (rules)
    );

    ppc_seq #(.ADDR_W(ADDR_W), .ITER_W(ITER_W), .LAT(LAT)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .mode_i         (mode),
        .limit_i        (limit),
        .words_i        (words),
        .wr_en_i        (wr_en),
        .word_changed_i (word_changed),
        .rd_en_o        (rd_en),
        .rd_addr_o      (rd_addr),
        .bank_o         (src_bank),
        .done_o         (done),
        .busy_o         (busy),
        .cfg_open_o     (cfg_open),
        .reason_o       (reason),
        .iter_o         (iter)
    );

    ppc_delay_line #(.W(PW), .DEPTH(LAT)) u_wdly (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  ({rd_en, rd_addr}),
        .out_o (wr_tag)
    );

    assign wr_en   = wr_tag[ADDR_W];
    assign wr_addr = wr_tag[ADDR_W-1:0];
endmodule

// File: rtl/ppc_checker.sv
module ppc_checker #(
    parameter int ADDR_W = 8,
    parameter int LAT    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              src_bank,
    input logic [127:0]      rules,
    input logic              done
);
    logic [LAT-1:0][ADDR_W:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q[0] <= {rd_en, rd_addr};
            for (int i = 1; i < LAT; i++) hist_q[i] <= hist_q[i-1];
        end
    end

    // R5
    wr_en_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en == hist_q[LAT-1][ADDR_W]);

    // R5
    wr_addr_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr == hist_q[LAT-1][ADDR_W-1:0]));

    // R4
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));

    // R4
    rd_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> (rd_addr == '0));

    // R6
    swap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_bank != $past(src_bank)) |-> (!$past(rd_en) && !$past(wr_en)));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_en && !wr_en));

    // R3
    rules_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> $stable(rules));
endmodule

bind pingpong_iter_ctrl ppc_checker #(.ADDR_W(ADDR_W), .LAT(LAT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .src_bank (src_bank),
    .rules    (rules),
    .done     (done)
);

// File: tb/pingpong_iter_ctrl_bench.sv
module pingpong_iter_ctrl_bench;
    localparam int ADDR_W = 8;
    localparam int ITER_W = 16;
    localparam int LAT    = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_we = 1'b0;
    logic [2:0]        host_addr = '0;
    logic [31:0]       host_wdata = '0;
    logic [31:0]       host_rdata;
    logic              word_changed = 1'b0;
    logic              rd_en, wr_en, src_bank, done;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [127:0]      rules;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 0;
    logic exp_bank = 1'b0;

    always #2 clk = ~clk;

    pingpong_iter_ctrl #(.ADDR_W(ADDR_W), .ITER_W(ITER_W), .LAT(LAT)) u_pingpong_iter_ctrl (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .word_changed(word_changed),
        .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
        .src_bank(src_bank), .rules(rules), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [31:0] d);
        host_addr = a;
        #0.5;
        d = host_rdata;
    endtask

    task automatic start_run(input int n, input int l, input bit mode);
        host_write(3'd3, n);
        host_write(3'd2, l);
        host_write(3'd0, {30'd0, mode, 1'b1});
    endtask

    // one pass from its first read cycle to the cycle after its swap
    task automatic run_pass(input int n, input bit chg_last, input bit chg_idle,
                            inout int e_rd, inout int e_wr, inout int e_bk);
        for (int c = 0; c <= n + LAT; c++) begin
            word_changed = (chg_last && c == n + LAT - 1) || (chg_idle && c == 0);
            #0.5;
            if (rd_en !== (c < n)) e_rd++;
            if (c < n && rd_addr !== ADDR_W'(c)) e_rd++;
            if (wr_en !== (c >= LAT && c < n + LAT)) e_wr++;
            if (c >= LAT && c < n + LAT && wr_addr !== ADDR_W'(c - LAT)) e_wr++;
            if (src_bank !== exp_bank) e_bk++;
            @(negedge clk);
        end
        word_changed = 1'b0;
        exp_bank = ~exp_bank;
    endtask

    task automatic check_end(input string req, input int passes, input bit reason);
        logic [31:0] st;
        host_read(3'd1, st);
        chk(done === 1'b1, req, "done raised", done, 1);
        chk(src_bank === exp_bank, "R6", "bank after run", src_bank, exp_bank);
        chk(st[31:8] == passes, req, "completed passes", st[31:8], passes);
        chk(st[3] == reason, req, "stop reason", st[3], reason);
        chk(st[1:0] == 2'b01 && st[2] == exp_bank, "R11", "status bits", st[3:0], {reason, exp_bank, 2'b01});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        int e_rd, e_wr, e_bk;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!rd_en && !wr_en && !done && !src_bank, "R1", "outputs idle",
            {rd_en, wr_en, done, src_bank}, 0);
        for (int a = 0; a < 8; a++) begin
            host_read(3'(a), rv);
            chk(rv == 0, "R1", $sformatf("reg %0d reset", a), rv, 0);
        end

        // R2 register writes and rule outputs
        for (int k = 0; k < 4; k++) host_write(3'(4 + k), 32'h1000_0001 * (k + 3));
        for (int k = 0; k < 4; k++) begin
            host_read(3'(4 + k), rv);
            chk(rv == 32'h1000_0001 * (k + 3), "R2", "rule readback", rv, 32'h1000_0001 * (k + 3));
            chk(rules[32*k +: 32] == 32'h1000_0001 * (k + 3), "R2", "rules port",
                rules[32*k +: 32], 32'h1000_0001 * (k + 3));
        end
        host_write(3'd2, 32'd9);
        host_read(3'd2, rv);
        chk(rv == 9, "R2", "limit readback", rv, 9);

        // R4 R5 R6 R7 R12 count-mode sweep
        for (int n = 1; n <= 5; n++) begin
            for (int l = 1; l <= 3; l++) begin
                e_rd = 0; e_wr = 0; e_bk = 0;
                start_run(n, l, 1'b0);
                for (int p = 0; p < l; p++) run_pass(n, 1'b0, 1'b0, e_rd, e_wr, e_bk);
                chk(e_rd == 0, "R4", $sformatf("read sequence n=%0d l=%0d", n, l), e_rd, 0);
                chk(e_wr == 0, "R5", $sformatf("write sequence n=%0d l=%0d", n, l), e_wr, 0);
                chk(e_bk == 0, "R6", $sformatf("bank per pass n=%0d l=%0d", n, l), e_bk, 0);
                check_end((n == 1 && l == 1) ? "R7" : "R12", l, 1'b0);
            end
        end
        repeat (3) @(negedge clk);
        chk(done && !rd_en && !wr_en, "R7", "quiet while done", {done, rd_en, wr_en}, 4);

        // R8 R9 settle mode: changes in passes 0,1; pass 2 changed only outside write cycles
        e_rd = 0; e_wr = 0; e_bk = 0;
        start_run(3, 10, 1'b1);
        run_pass(3, 1'b1, 1'b0, e_rd, e_wr, e_bk);
        run_pass(3, 1'b1, 1'b0, e_rd, e_wr, e_bk);
        run_pass(3, 1'b0, 1'b1, e_rd, e_wr, e_bk);
        chk(e_rd + e_wr + e_bk == 0, "R8", "settle traffic", e_rd + e_wr + e_bk, 0);
        check_end("R9", 3, 1'b1);
        host_read(3'd0, rv);
        chk(rv[1] == 1'b1, "R4", "mode bit readback", rv[1], 1);

        // R8 settle mode bounded by the pass limit
        start_run(3, 2, 1'b1);
        run_pass(3, 1'b1, 1'b0, e_rd, e_wr, e_bk);
        run_pass(3, 1'b1, 1'b0, e_rd, e_wr, e_bk);
        chk(e_rd + e_wr + e_bk == 0, "R8", "limited settle traffic", e_rd + e_wr + e_bk, 0);
        check_end("R8", 2, 1'b0);

        // R10 zero words, then zero limit
        start_run(0, 3, 1'b0);
        chk(done && !rd_en, "R10", "zero words done", {done, rd_en}, 2);
        check_end("R10", 0, 1'b0);
        @(negedge clk);
        chk(!rd_en && !wr_en, "R10", "zero words no traffic", {rd_en, wr_en}, 0);
        start_run(4, 0, 1'b0);
        chk(done && !rd_en, "R10", "zero limit done", {done, rd_en}, 2);
        check_end("R10", 0, 1'b0);

        // R3 writes during a run are dropped
        start_run(6, 1, 1'b0);
        host_read(3'd1, rv);
        chk(rv[1:0] == 2'b10, "R11", "busy during run", rv[1:0], 2);
        host_write(3'd4, 32'hDEAD_BEEF);
        host_write(3'd2, 32'd7);
        host_write(3'd0, 32'd3);
        for (int w = 0; w < 40 && !done; w++) @(negedge clk);
        exp_bank = ~exp_bank;
        host_read(3'd4, rv);
        chk(rv == 32'h3000_0003, "R3", "rule 0 kept", rv, 32'h3000_0003);
        chk(rules[31:0] == 32'h3000_0003, "R3", "rules port kept", rules[31:0], 32'h3000_0003);
        host_read(3'd2, rv);
        chk(rv == 1, "R3", "limit kept", rv, 1);
        host_read(3'd0, rv);
        chk(rv[1] == 1'b0, "R3", "mode kept", rv[1], 0);
        check_end("R3", 1, 1'b0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule